// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the 32-bit register storage of a small load-store core. Sixteen architectural registers are visible at any moment. Index 13 is the stack pointer, index 14 is the link register and index 15 is the program counter. Two combinational read ports drive operand buses A and B. One synchronous write port takes the result bus. The program counter is read and written like any other index.

A 5-bit processor-mode input selects the physical storage behind indices 13 and 14. Each exception mode (fast interrupt, interrupt, supervisor, abort, undefined) has its own stack pointer and link register. User mode and System mode share one set. Each exception mode also has its own saved-status word, which has a separate read/write port. In User and System mode there is no saved-status word.

Indices 0 to 12 and index 15 are a single set that every mode shares. An unknown mode code is handled exactly as User mode.

Top module: `mode_banked_regfile`

## Requirements
- R1: After reset is released, every index on both read ports reads 0 in every mode, and the saved-status read port reads 0.
- R2: A write with `wr_en`=1 at a rising edge is visible on both read ports from that edge onward, for the same index and mode.
- R3: While a write to an index is pending in a cycle, a read of that index in the same cycle returns the old value.
- R4: Indices 0–12 and 15 are shared by all modes. A value written in one mode reads back unchanged in every other mode.
- R5: Indices 13 and 14 map to a separate copy for each exception mode. The mode codes are fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111 and undefined 5'b11011. A write in one of these modes changes no other mode's copy.
- R6: User mode (5'b10000) and System mode (5'b11111) share the same index 13 and 14 storage.
- R7: Each exception mode of R5 has its own saved-status word, written through `sps_wr_en`/`sps_wr_data` and read on `sps_rd_data`. In User and System mode, `sps_rd_data` reads 0 and a saved-status write changes nothing.
- R8: Any mode code not listed in R5 or R6 (for example 5'b00000) uses the User mapping for indices 13 and 14, and has no saved-status word.
- R9: With `wr_en`=0, a rising edge changes no register. This holds whatever values `wr_idx` and `wr_data` carry.
- R10: A saved-status read in the same cycle as a saved-status write returns the old value. The new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low; clears all storage |
| mode | input | 5 | Current processor mode code |
| rd_a_idx | input | 4 | Architectural index for operand bus A |
| rd_a_data | output | 32 | Operand bus A, combinational |
| rd_b_idx | input | 4 | Architectural index for operand bus B |
| rd_b_data | output | 32 | Operand bus B, combinational |
| wr_en | input | 1 | Result bus write enable |
| wr_idx | input | 4 | Architectural index to write |
| wr_data | input | 32 | Result bus value |
| sps_wr_en | input | 1 | Saved-status write enable |
| sps_wr_data | input | 32 | Saved-status value to write |
| sps_rd_data | output | 32 | Saved-status word of the current mode, combinational |

## Verification
Read results are combinational. They change in the same cycle as `mode` or an index changes, so the bench drives inputs on the falling edge and samples one time unit later. A write lands at the next rising edge. The bench therefore samples the new value at the falling edge after that rising edge, and samples the old value before that rising edge to cover the same-cycle cases of R3 and R10. The checker makes the same one-edge comparisons, using `$past` of the write inputs.

// File: rtl/rbank_pkg.sv
// Package: shared sizes, mode codes and bank numbering for the banked register file.
// Assumes a 5-bit mode code and one bank per exception mode.
package rbank_pkg;
    localparam int DATA_W    = 32;
    localparam int ARCH_REGS = 16;
    localparam int IDX_W     = 4;
    localparam int MODE_W    = 5;
    localparam int SP_IDX    = 13;
    localparam int LR_IDX    = 14;
    localparam int XBANKS    = 5;
    localparam int BANK_W    = 3;

    localparam logic [MODE_W-1:0] M_USR = 5'b10000;
    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;
    localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

    typedef enum logic [BANK_W-1:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;
endpackage

// File: rtl/rb_mode_decode.sv
// Module: rb_mode_decode
// Maps a mode code to a bank number. Bank 0 is the shared User/System set.
// Banks 1..XBANKS are the exception modes.
// Assumes: unknown codes fall back to bank 0. Purely combinational.
module rb_mode_decode
    import rbank_pkg::*;
#(
    parameter int MW = MODE_W,
    parameter int BW = BANK_W
) (
    input  logic [MW-1:0] mode,
    output logic [BW-1:0] bank,
    output logic          is_exc
);
    bank_e bank_n;

    // Purpose: translate mode code to bank number.
    always_comb begin
        case (mode)
            M_FIQ:   bank_n = BK_FIQ;
            M_IRQ:   bank_n = BK_IRQ;
            M_SVC:   bank_n = BK_SVC;
            M_ABT:   bank_n = BK_ABT;
            M_UND:   bank_n = BK_UND;
            default: bank_n = BK_USR;
        endcase
    end

    assign bank   = BW'(bank_n);
    assign is_exc = (bank_n != BK_USR);
endmodule

// File: rtl/rb_index_map.sv
// Module: rb_index_map
// Turns an architectural index and a bank number into a physical slot.
// Slots 0..NARCH-1 hold the shared set, including User/System SP and LR.
// Exception banks start at NARCH, two slots per bank (SP, then LR).
// Assumes bank is 0..NXB.
module rb_index_map #(
    parameter int IW    = 4,
    parameter int BW    = 3,
    parameter int PW    = 5,
    parameter int NARCH = 16,
    parameter int SPI   = 13,
    parameter int LRI   = 14
) (
    input  logic [IW-1:0] arch_idx,
    input  logic [BW-1:0] bank,
    output logic [PW-1:0] phys_idx
);
    logic banked;

    // Purpose: detect a banked index in an exception bank.
    always_comb begin
        banked = ((int'(arch_idx) == SPI) || (int'(arch_idx) == LRI)) && (bank != '0);
    end

    // Purpose: compute the physical slot.
    always_comb begin
        if (banked)
            phys_idx = PW'(NARCH + 2 * (int'(bank) - 1) + (int'(arch_idx) - SPI));
        else
            phys_idx = PW'(arch_idx);
    end
endmodule

// File: rtl/rb_gpr_store.sv
// Module: rb_gpr_store
// Flop-based storage with one synchronous write port and two combinational read ports.
// Reads return the value before the edge, so a read of a slot being written sees the old value.
// Assumes all indices are below NSLOT.
module rb_gpr_store #(
    parameter int DW    = 32,
    parameter int NSLOT = 26,
    parameter int PW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] w_idx,
    input  logic [DW-1:0] w_data,
    input  logic [PW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [PW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] slot_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Purpose: clear or load one storage slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (we && (int'(w_idx) == g))
                slot_q[g] <= w_data;
        end
    end

    // Purpose: read mux for operand bus A.
    always_comb begin
        ra_data = '0;
        for (int i = 0; i < NSLOT; i++)
            if (int'(ra_idx) == i) ra_data = slot_q[i];
    end

    // Purpose: read mux for operand bus B.
    always_comb begin
        rb_data = '0;
        for (int i = 0; i < NSLOT; i++)
            if (int'(rb_idx) == i) rb_data = slot_q[i];
    end
endmodule

// File: rtl/rb_saved_status.sv
// Module: rb_saved_status
// One saved-status word per exception bank.
// Writes and reads are gated by is_exc; without an exception bank the read is 0 and writes drop.
// Assumes bank is 1..NXB whenever is_exc is high.
module rb_saved_status #(
    parameter int DW  = 32,
    parameter int NXB = 5,
    parameter int BW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] bank,
    input  logic          is_exc,
    input  logic          we,
    input  logic [DW-1:0] w_data,
    output logic [DW-1:0] r_data
);
    logic [DW-1:0] sps_q [NXB];

    for (genvar g = 0; g < NXB; g++) begin : g_bank
        // Purpose: clear or load the saved-status word of bank g+1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sps_q[g] <= '0;
            else if (we && is_exc && (int'(bank) == g + 1))
                sps_q[g] <= w_data;
        end
    end

    // Purpose: select the current bank's word, or 0 with no bank.
    always_comb begin
        r_data = '0;
        for (int i = 0; i < NXB; i++)
            if (is_exc && (int'(bank) == i + 1)) r_data = sps_q[i];
    end
endmodule

// File: rtl/mode_banked_regfile.sv
// Module: mode_banked_regfile (top)
// Register file with 16 architectural registers, two read ports and one write port.
// SP, LR and the saved-status word are banked by processor mode.
// Assumes the mode input is stable around the clock edge, like any other write input.
module mode_banked_regfile
    import rbank_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DW-1:0]     rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              sps_wr_en,
    input  logic [DW-1:0]     sps_wr_data,
    output logic [DW-1:0]     sps_rd_data
);
    localparam int NSLOT  = ARCH_REGS + 2 * XBANKS;
    localparam int PW     = $clog2(NSLOT);
    localparam int NPORTS = 3;

    logic [BANK_W-1:0] bank;
    logic              is_exc;
    logic [IDX_W-1:0]  arch_idx [NPORTS];
    logic [PW-1:0]     phys_idx [NPORTS];

    rb_mode_decode #(.MW(MODE_W), .BW(BANK_W)) u_dec (
        .mode   (mode),
        .bank   (bank),
        .is_exc (is_exc)
    );

    assign arch_idx[0] = rd_a_idx;
    assign arch_idx[1] = rd_b_idx;
    assign arch_idx[2] = wr_idx;

    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        rb_index_map #(
            .IW(IDX_W), .BW(BANK_W), .PW(PW),
            .NARCH(ARCH_REGS), .SPI(SP_IDX), .LRI(LR_IDX)
        ) u_map (
            .arch_idx (arch_idx[p]),
            .bank     (bank),
            .phys_idx (phys_idx[p])
        );
    end

    rb_gpr_store #(.DW(DW), .NSLOT(NSLOT), .PW(PW)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .w_idx   (phys_idx[2]),
        .w_data  (wr_data),
        .ra_idx  (phys_idx[0]),
        .ra_data (rd_a_data),
        .rb_idx  (phys_idx[1]),
        .rb_data (rd_b_data)
    );

    rb_saved_status #(.DW(DW), .NXB(XBANKS), .BW(BANK_W)) u_sps (
        .clk    (clk),
        .rst_n  (rst_n),
        .bank   (bank),
        .is_exc (is_exc),
        .we     (sps_wr_en),
        .w_data (sps_wr_data),
        .r_data (sps_rd_data)
    );
endmodule

// File: rtl/mode_banked_regfile_chk.sv
// Module: mode_banked_regfile_chk
// Port-level properties of the banked register file, attached to the top with bind.
module mode_banked_regfile_chk
    import rbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [IDX_W-1:0]  rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              sps_wr_en,
    input logic [DATA_W-1:0] sps_wr_data,
    input logic [DATA_W-1:0] sps_rd_data
);
    logic armed;
    logic exc_mode;

    // Purpose: arm the checks one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign exc_mode = (mode == M_FIQ) || (mode == M_IRQ) || (mode == M_SVC) ||
                      (mode == M_ABT) || (mode == M_UND);

    // R2: a written value appears on bus A after the edge, in the same mode.
    a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en) |=>
            (!($stable(mode) && rd_a_idx == $past(wr_idx)) || rd_a_data == $past(wr_data)));

    // R4 / R9: shared indices keep their value across a mode change when nothing is written.
    a_r4_shared_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !wr_en) |=>
            (!($stable(rd_a_idx) && (rd_a_idx < 4'd13 || rd_a_idx == 4'd15)) || $stable(rd_a_data)));

    // R9: with no write and stable selection, bus B does not change.
    a_r9_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !wr_en) |=> (!($stable(mode) && $stable(rd_b_idx)) || $stable(rd_b_data)));

    // R7: no saved-status word outside the exception modes.
    a_r7_sps_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !exc_mode) |-> sps_rd_data == '0);

    // R10: a saved-status write in an exception mode shows after the edge.
    a_r10_sps_write: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sps_wr_en && exc_mode) |=>
            (!$stable(mode) || sps_rd_data == $past(sps_wr_data)));
endmodule

bind mode_banked_regfile mode_banked_regfile_chk u_chk (.*);

// File: tb/sim_mode_banked_regfile.sv
// Bench: directed scenarios for mode_banked_regfile, one task each.
module sim_mode_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sps_wr_data = '0, sps_rd_data;
    logic        wr_en = 1'b0, sps_wr_en = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111, BAD = 5'b00000;
    localparam logic [4:0] EXC [5] = '{FIQ, IRQ, SVC, ABT, UND};

    always #5 clk = ~clk;

    mode_banked_regfile u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sps_wr_en(sps_wr_en), .sps_wr_data(sps_wr_data), .sps_rd_data(sps_rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FIAL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register through the result bus; returns at the falling edge after the write.
    task automatic wr(input logic [4:0] m, input int idx, input logic [31:0] d);
        @(negedge clk);
        mode = m; wr_idx = 4'(idx); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read one index on both buses in mode m.
    task automatic rd(input logic [4:0] m, input int idx, output logic [31:0] va, output logic [31:0] vb);
        mode = m; rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
        #1;
        va = rd_a_data; vb = rd_b_data;
    endtask

    task automatic sps_wr(input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        mode = m; sps_wr_data = d; sps_wr_en = 1'b1;
        @(negedge clk);
        sps_wr_en = 1'b0;
    endtask

    task automatic sps_rd(input logic [4:0] m, output logic [31:0] v);
        mode = m; #1; v = sps_rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        for (int m = 0; m < 5; m++)
            for (int i = 0; i < 16; i++) begin
                rd(EXC[m], i, a, b);
                chk("R1 reset bus A", a, 32'h0);
                chk("R1 reset bus B", b, 32'h0);
            end
        for (int i = 0; i < 16; i++) begin
            rd(USR, i, a, b);
            chk("R1 reset user", a, 32'h0);
        end
        sps_rd(SVC, a);
        chk("R1 reset saved status", a, 32'h0);
    endtask

    task automatic t_basic;
        logic [31:0] a, b;
        for (int i = 0; i < 16; i++) wr(USR, i, 32'hA000_0000 + 32'(i));
        for (int i = 0; i < 16; i++) begin
            rd(USR, i, a, b);
            chk("R2 bus A", a, 32'hA000_0000 + 32'(i));
            chk("R2 bus B", b, 32'hA000_0000 + 32'(i));
        end
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        mode = USR; wr_idx = 4'd3; wr_data = 32'h1234_5678; wr_en = 1'b1;
        rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        #1;
        chk("R3 old value before edge", rd_a_data, 32'hA000_0003);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R3 new value after edge", rd_b_data, 32'h1234_5678);
    endtask

    task automatic t_shared;
        logic [31:0] a, b;
        wr(IRQ, 5, 32'h0000_5555);
        wr(SVC, 15, 32'h0000_8000);
        wr(FIQ, 12, 32'h0000_0C0C);
        for (int m = 0; m < 5; m++) begin
            rd(EXC[m], 5, a, b);   chk("R4 r5 shared", a, 32'h0000_5555);
            rd(EXC[m], 15, a, b);  chk("R4 pc shared", b, 32'h0000_8000);
            rd(EXC[m], 12, a, b);  chk("R4 r12 shared", a, 32'h0000_0C0C);
        end
        rd(USR, 15, a, b); chk("R4 pc in user", a, 32'h0000_8000);
        rd(SYS, 12, a, b); chk("R4 r12 in system", a, 32'h0000_0C0C);
    endtask

    task automatic t_banked;
        logic [31:0] a, b;
        for (int m = 0; m < 5; m++) begin
            wr(EXC[m], 13, 32'h5000_0000 + 32'(m));
            wr(EXC[m], 14, 32'h1000_0000 + 32'(m));
        end
        for (int m = 0; m < 5; m++) begin
            rd(EXC[m], 13, a, b); chk("R5 banked sp", a, 32'h5000_0000 + 32'(m));
            rd(EXC[m], 14, a, b); chk("R5 banked lr", b, 32'h1000_0000 + 32'(m));
        end
        rd(USR, 13, a, b); chk("R5 user sp untouched", a, 32'hA000_000D);
        rd(USR, 14, a, b); chk("R5 user lr untouched", a, 32'hA000_000E);
    endtask

    task automatic t_system;
        logic [31:0] a, b;
        wr(SYS, 13, 32'h0000_5150);
        wr(USR, 14, 32'h0000_0E1E);
        rd(USR, 13, a, b); chk("R6 sp shared user/system", a, 32'h0000_5150);
        rd(SYS, 14, a, b); chk("R6 lr shared user/system", b, 32'h0000_0E1E);
        rd(ABT, 13, a, b); chk("R6 abort sp separate", a, 32'h5000_0003);
    endtask

    task automatic t_saved;
        logic [31:0] v;
        for (int m = 0; m < 5; m++) sps_wr(EXC[m], 32'h0000_00D0 + 32'(m));
        for (int m = 0; m < 5; m++) begin
            sps_rd(EXC[m], v); chk("R7 per-mode saved status", v, 32'h0000_00D0 + 32'(m));
        end
        sps_wr(USR, 32'hDEAD_BEEF);
        sps_rd(USR, v); chk("R7 user reads zero", v, 32'h0);
        sps_wr(SYS, 32'hFEED_FACE);
        sps_rd(SYS, v); chk("R7 system reads zero", v, 32'h0);
        for (int m = 0; m < 5; m++) begin
            sps_rd(EXC[m], v); chk("R7 user write ignored", v, 32'h0000_00D0 + 32'(m));
        end
    endtask

    task automatic t_bad_mode;
        logic [31:0] a, b;
        wr(BAD, 13, 32'h0BAD_0013);
        rd(USR, 13, a, b); chk("R8 unknown mode uses user sp", a, 32'h0BAD_0013);
        rd(BAD, 14, a, b); chk("R8 unknown mode reads user lr", a, 32'h0000_0E1E);
        sps_rd(BAD, a);    chk("R8 unknown mode saved status zero", a, 32'h0);
        rd(FIQ, 13, a, b); chk("R8 fiq sp untouched", a, 32'h5000_0000);
    endtask

    task automatic t_no_write;
        logic [31:0] a, b;
        @(negedge clk);
        mode = SVC; wr_idx = 4'd7; wr_data = 32'hFFFF_FFFF; wr_en = 1'b0;
        @(negedge clk);
        wr_idx = 4'd13;
        @(negedge clk);
        rd(SVC, 7, a, b);  chk("R9 r7 unchanged", a, 32'hA000_0007);
        rd(SVC, 13, a, b); chk("R9 svc sp unchanged", a, 32'h5000_0002);
    endtask

    task automatic t_sps_same_cycle;
        @(negedge clk);
        mode = IRQ; sps_wr_data = 32'h0000_7777; sps_wr_en = 1'b1;
        #1;
        chk("R10 saved status old before edge", sps_rd_data, 32'h0000_00D1);
        @(negedge clk);
        sps_wr_en = 1'b0;
        #1;
        chk("R10 saved status new after edge", sps_rd_data, 32'h0000_7777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_same_cycle;
        t_shared;
        t_banked;
        t_system;
        t_saved;
        t_bad_mode;
        t_no_write;
        t_sps_same_cycle;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule